// File: doc/BRIEF.md
# Registered Four-Function ALU

This block is a small pipelined arithmetic logic unit for narrow datapaths. On each rising clock edge it captures two operands, a carry-in bit and a two-bit function code. From those captured values it evaluates four results at the same time: bitwise NAND, bitwise NOR, bitwise XOR and a ripple-carry sum. A multiplexer for each result bit picks one of the four. The chosen word is captured in an output register on the next edge.

A new operation can be presented on every cycle. Each result appears two rising edges after its operands were applied. The sum has no carry output, so it wraps around at the word size. A synchronous active-high reset clears both the input stage and the output stage.

Top module: `alu4_reg`

## Requirements
- R1: Function code 2'b00 (sel_i[1]=0, sel_i[0]=0) yields the bitwise NAND of the two operands.
- R2: Function code 2'b10 (sel_i[1]=1, sel_i[0]=0) yields the bitwise NOR of the two operands.
- R3: Function code 2'b01 (sel_i[1]=0, sel_i[0]=1) yields the bitwise XOR of the two operands.
- R4: Function code 2'b11 yields (a_i + b_i + cin_i) modulo 2^WIDTH. The carry out of the top bit is dropped. For example, 8+8+0 gives 0 and 15+15+1 gives 15.
- R5: Operands, carry-in and function code sampled at rising edge k determine res_o after rising edge k+1. Back-to-back operations with a different function on every cycle are each reported in order.
- R6: While rst is high at a rising edge, res_o becomes all zeros after that edge. This also applies when reset arrives in the middle of a stream of operations.
- R7: Reset also clears the captured operands, carry and function code to zero. The first result after reset is released is therefore the NAND of two zero words, which is all ones.
- R8: cin_i affects only the sum. Under codes 2'b00, 2'b01 and 2'b10 the result is the same for cin_i=0 and cin_i=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset for both register stages |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into the least significant adder stage |
| sel_i | input | 2 | Function code: 00 NAND, 01 XOR, 10 NOR, 11 ADD |
| res_o | output | WIDTH | Registered result |

## Verification
The bench builds the block with its default WIDTH of 4. At that width the full space of 2048 operand, carry and code combinations can be sampled densely by seeded random stimulus. The same width makes the modulo-16 wrap of the sum and the all-ones and all-zeros operand patterns easy to reach with directed vectors. Directed sequences also apply a reset in the middle of a stream, check the all-ones word that follows reset release, and present the same operands with both carry-in values under every logic code.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    typedef enum logic [1:0] {
        FN_NAND = 2'b00,
        FN_XOR  = 2'b01,
        FN_NOR  = 2'b10,
        FN_ADD  = 2'b11
    } alu_fn_e;

endpackage

// File: rtl/alu4_capture.sv
module alu4_capture
    import alu4_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    input  logic [1:0]       sel_i,
    output logic [WIDTH-1:0] a_q,
    output logic [WIDTH-1:0] b_q,
    output logic             cin_q,
    output alu_fn_e          fn_q
);

    // Operands, carry and function code are registered together so they stay aligned
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            cin_q <= 1'b0;
            fn_q  <= FN_NAND;
        end else begin
            a_q   <= a_i;
            b_q   <= b_i;
            cin_q <= cin_i;
            fn_q  <= alu_fn_e'(sel_i);
        end
    end

    AST_CAPTURE_CLEAR: assert property (@(posedge clk) rst |=> (a_q == '0 && b_q == '0 && !cin_q && fn_q == FN_NAND)); // R7

endmodule

// File: rtl/alu4_units.sv
module alu4_units #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_q,
    input  logic [WIDTH-1:0] b_q,
    input  logic             cin_q,
    output logic [WIDTH-1:0] nand_v,
    output logic [WIDTH-1:0] nor_v,
    output logic [WIDTH-1:0] xor_v,
    output logic [WIDTH-1:0] sum_v
);

    // carry into each stage; the carry out of the top stage is never formed
    logic [WIDTH-1:0] carry;

    assign carry[0] = cin_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        assign nand_v[g] = ~(a_q[g] & b_q[g]);
        assign nor_v[g]  = ~(a_q[g] | b_q[g]);
        assign xor_v[g]  = a_q[g] ^ b_q[g];
        assign sum_v[g]  = a_q[g] ^ b_q[g] ^ carry[g];
        if (g < WIDTH - 1) begin : g_carry
            assign carry[g+1] = (a_q[g] & b_q[g]) | (carry[g] & (a_q[g] ^ b_q[g]));
        end
    end

endmodule

// File: rtl/alu4_select.sv
module alu4_select
    import alu4_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  alu_fn_e          fn_q,
    input  logic [WIDTH-1:0] nand_v,
    input  logic [WIDTH-1:0] nor_v,
    input  logic [WIDTH-1:0] xor_v,
    input  logic [WIDTH-1:0] sum_v,
    output logic [WIDTH-1:0] pick_o
);

    // one four-way multiplexer per result bit
    for (genvar g = 0; g < WIDTH; g++) begin : g_mux
        logic bit_v;
        always_comb begin
            unique case (fn_q)
                FN_NAND: bit_v = nand_v[g];
                FN_XOR:  bit_v = xor_v[g];
                FN_NOR:  bit_v = nor_v[g];
                FN_ADD:  bit_v = sum_v[g];
                default: bit_v = 1'b0;
            endcase
        end
        assign pick_o[g] = bit_v;
    end

endmodule

// File: rtl/alu4_reg.sv
module alu4_reg
    import alu4_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    input  logic [1:0]       sel_i,
    output logic [WIDTH-1:0] res_o
);

    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;
    logic             cin_q;
    alu_fn_e          fn_q;
    logic [WIDTH-1:0] nand_v;
    logic [WIDTH-1:0] nor_v;
    logic [WIDTH-1:0] xor_v;
    logic [WIDTH-1:0] sum_v;
    logic [WIDTH-1:0] pick_v;
    logic [WIDTH-1:0] cin_ext;

    assign cin_ext = {{(WIDTH-1){1'b0}}, cin_q};

    alu4_capture #(.WIDTH(WIDTH)) u_capture (
        .clk   (clk),
        .rst   (rst),
        .a_i   (a_i),
        .b_i   (b_i),
        .cin_i (cin_i),
        .sel_i (sel_i),
        .a_q   (a_q),
        .b_q   (b_q),
        .cin_q (cin_q),
        .fn_q  (fn_q)
    );

    alu4_units #(.WIDTH(WIDTH)) u_units (
        .a_q    (a_q),
        .b_q    (b_q),
        .cin_q  (cin_q),
        .nand_v (nand_v),
        .nor_v  (nor_v),
        .xor_v  (xor_v),
        .sum_v  (sum_v)
    );

    alu4_select #(.WIDTH(WIDTH)) u_select (
        .fn_q   (fn_q),
        .nand_v (nand_v),
        .nor_v  (nor_v),
        .xor_v  (xor_v),
        .sum_v  (sum_v),
        .pick_o (pick_v)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o <= '0;
        end else begin
            res_o <= pick_v;
        end
    end

    AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (res_o == '0)); // R6
    AST_NAND_PICK:  assert property (@(posedge clk) disable iff (rst) (fn_q == FN_NAND) |=> (res_o == ~$past(a_q & b_q))); // R1
    AST_NOR_PICK:   assert property (@(posedge clk) disable iff (rst) (fn_q == FN_NOR)  |=> (res_o == ~$past(a_q | b_q))); // R2
    AST_XOR_PICK:   assert property (@(posedge clk) disable iff (rst) (fn_q == FN_XOR)  |=> (res_o == $past(a_q ^ b_q))); // R3
    AST_SUM_WRAP:   assert property (@(posedge clk) disable iff (rst) (fn_q == FN_ADD)  |=> (res_o == $past(a_q + b_q + cin_ext))); // R4

endmodule

// File: tb/tb_alu4_reg.sv
`timescale 1ns/1ps
module tb_alu4_reg;

    localparam int W   = 4;
    localparam int CLK = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         cin_i = 1'b0;
    logic [1:0]   sel_i = 2'b00;
    logic [W-1:0] res_o;

    int    n_run  = 0;
    int    n_fail = 0;
    logic [W-1:0] e_old, e_new;
    string        t_old, t_new;
    logic         v_old, v_new;

    always #(CLK/2) clk = ~clk;

    alu4_reg #(.WIDTH(W)) dut (
        .clk   (clk),
        .rst   (rst),
        .a_i   (a_i),
        .b_i   (b_i),
        .cin_i (cin_i),
        .sel_i (sel_i),
        .res_o (res_o)
    );

    function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b, logic c, logic [1:0] s);
        case (s)
            2'b00:   return ~(a & b);
            2'b10:   return ~(a | b);
            2'b01:   return a ^ b;
            default: return W'(a + b + W'(c));
        endcase
    endfunction

    function automatic string tag_of(logic [1:0] s);
        case (s)
            2'b00:   return "R1";
            2'b10:   return "R2";
            2'b01:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s: res_o=%h expected=%h", req, got, exp);
        end
    endtask

    // one cycle: drive at negedge, wait an edge, compare against the op two steps back (R5)
    task automatic step(logic [W-1:0] a, logic [W-1:0] b, logic c, logic [1:0] s);
        a_i = a; b_i = b; cin_i = c; sel_i = s;
        e_old = e_new; t_old = t_new; v_old = v_new;
        e_new = model(a, b, c, s); t_new = tag_of(s); v_new = 1'b1;
        @(posedge clk); @(negedge clk);
        if (v_old) check({t_old, "/R5"}, res_o, e_old);
    endtask

    task automatic do_reset(int cycles);
        rst = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); @(negedge clk);
            check("R6", res_o, '0);
        end
        rst = 1'b0;
        // captured stage is zero with code 00, so the first result is all ones (R7)
        e_new = {W{1'b1}}; t_new = "R7"; v_new = 1'b1;
    endtask

    initial begin
        #(CLK * 200000);
        n_fail++;
        $display("[TB] FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] r_nc, r_c;
        void'($urandom(32'd20240517));
        v_new = 1'b0; e_new = '0; t_new = "";
        @(negedge clk);
        do_reset(2);

        // directed corner cases
        step(4'h0, 4'h0, 1'b0, 2'b00);          // R7 checked here, NAND 0,0 -> F
        step(4'h0, 4'h0, 1'b0, 2'b10);          // NOR 0,0 -> F
        step(4'hA, 4'h5, 1'b0, 2'b01);          // XOR -> F
        step(4'h8, 4'h8, 1'b0, 2'b11);          // R4 wrap -> 0
        step(4'hF, 4'hF, 1'b1, 2'b11);          // R4 31 mod 16 -> F
        step(4'hF, 4'h1, 1'b0, 2'b11);          // R4 wrap -> 0
        step(4'hF, 4'hF, 1'b0, 2'b00);          // NAND -> 0
        step(4'hC, 4'hA, 1'b1, 2'b10);          // NOR -> 1
        step(4'h3, 4'h3, 1'b1, 2'b01);          // XOR -> 0

        // mid-stream reset (R6) then restart
        step(4'h7, 4'h6, 1'b0, 2'b11);
        do_reset(1);
        step(4'h5, 4'h9, 1'b1, 2'b11);
        step(4'h1, 4'h2, 1'b0, 2'b01);

        // R8: carry-in has no effect on the logic codes
        for (int s = 0; s < 3; s++) begin
            logic [1:0] sc;
            sc = (s == 0) ? 2'b00 : (s == 1) ? 2'b01 : 2'b10;
            step(4'h6, 4'hB, 1'b0, sc);
            step(4'h6, 4'hB, 1'b1, sc);
            r_nc = model(4'h6, 4'hB, 1'b0, sc);
            step(4'h0, 4'h0, 1'b0, 2'b00);
            r_c = res_o;
            check("R8", r_c, r_nc);
            step(4'h0, 4'h0, 1'b0, 2'b00);
        end

        // constrained random, every cycle a new op (R1..R5)
        for (int i = 0; i < 400; i++) begin
            step(W'($urandom), W'($urandom), 1'($urandom), 2'($urandom));
        end
        step(4'h0, 4'h0, 1'b0, 2'b00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule